// File: doc/BRIEF.md
# Data Tenure Grant Qualifier

This block sits on the master side of a split-transaction bus, where address and data phases run separately. It watches the local transfer-start strobe and the address-only flag. Each address tenure that needs data is recorded in a small in-order queue together with its length. No separate data request pin exists, because a queued tenure is itself the request.

For the oldest queued tenure, the block checks three shared lines each cycle: an externally driven data grant, the shared data-busy line and the address-retry line. When the grant is valid it raises a single-cycle start pulse and pops the entry. It then drives its own busy output for one or four beats. A retry that arrives while a tenure is queued discards the oldest entry. A mode input for internal-only operation switches the whole qualifier off.

Top module: `data_tenure_gate`

## Requirements
- R1: After synchronous reset, `tenure_start` and `busy_out` are low and no tenure is queued.
- R2: A cycle with `xfer_start` high and `addr_only` low queues one tenure. From the next cycle on, that tenure can start. A grant with no queued tenure produces no start.
- R3: A strobe with `addr_only` high queues nothing and never leads to a start, even with the grant held high.
- R4: `tenure_start` is high for exactly one cycle per queued tenure. It is driven in the same cycle as the qualifying inputs: a tenure is queued, `grant_in` is 1, `busy_in` is 0, `retry_in` is 0 and `busy_out` is 0. Tenures start in the order their strobes arrived. A strobe in the cycle of a start is queued behind the remaining entries.
- R5: While `grant_in` is 0, no queued tenure starts, and queued tenures are kept.
- R6: While `busy_in` is 1, no queued tenure starts.
- R7: `retry_in` high while a tenure is queued removes the oldest entry, and no start occurs in that cycle. The next entry becomes the oldest.
- R8: After a start, `busy_out` is high from the next cycle for the tenure's length. The length is 1 cycle if `long_burst` was 0 with the strobe, and 4 cycles if it was 1.
- R9: While `busy_out` is high, no further tenure starts. A second queued tenure starts in the first cycle after `busy_out` falls in which the grant is valid.
- R10: At most 2 tenures are queued. A strobe that arrives while 2 are queued, with no start or retry in that cycle, is dropped.
- R11: While `internal_only` is 1, strobes are not queued, no start occurs, and every queued tenure is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| internal_only | input | 1 | 1 = bus internal only, qualifier disabled |
| xfer_start | input | 1 | Address tenure start strobe |
| addr_only | input | 1 | 1 = tenure carries no data phase |
| long_burst | input | 1 | Sampled with the strobe: 1 = 4-beat tenure, 0 = single beat |
| grant_in | input | 1 | Externally driven data bus grant |
| busy_in | input | 1 | Shared data-busy line from other masters |
| retry_in | input | 1 | Address retry for the oldest queued tenure |
| tenure_start | output | 1 | One-cycle pulse: data tenure begins |
| busy_out | output | 1 | This master holds the data bus |

## Verification
The hardest case to reach is the one where the queue holds two tenures and something other than the grant changes which of them reaches the bus. That something is either a retry that removes the older entry, or a third strobe that has to be dropped. To get there, the stimulus sends back-to-back strobes with the grant held low, so both entries stay queued. It then releases the grant or pulses retry. The beat count seen on `busy_out` after each start shows which entry actually started, because the two entries carry different lengths.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;

    // One queued data tenure: only its length has to be remembered.
    typedef struct packed {
        logic long_burst;
    } dtg_entry_t;

    // Decision taken for the oldest queued tenure in a cycle.
    typedef enum logic [1:0] {
        DQ_IDLE = 2'd0,   // nothing queued
        DQ_HOLD = 2'd1,   // queued, grant not valid
        DQ_DROP = 2'd2,   // retried: discard oldest entry
        DQ_GO   = 2'd3    // valid grant: start tenure
    } dq_act_t;

    function automatic int unsigned tenure_beats(input logic long_b,
                                                 input int unsigned short_n,
                                                 input int unsigned long_n);
        return long_b ? long_n : short_n;
    endfunction

endpackage

// File: rtl/dtg_pend_fifo.sv
`timescale 1ns/1ps
module dtg_pend_fifo
    import dtg_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       push,
    input  dtg_entry_t push_data,
    input  logic       pop,
    output logic       head_valid,
    output dtg_entry_t head_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    dtg_entry_t         mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [CNT_W-1:0]   count;
    logic               full;
    logic               push_ok;
    logic               pop_ok;

    assign full       = (count == CNT_W'(DEPTH));
    assign head_valid = (count != '0);
    assign head_data  = mem[rd_ptr];
    assign pop_ok     = pop && head_valid;
    assign push_ok    = push && (!full || pop_ok);

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (push_ok && !flush && wr_ptr == PTR_W'(i)) begin
                mem[i] <= push_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/dtg_busy_timer.sv
`timescale 1ns/1ps
module dtg_busy_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/dtg_qualify.sv
`timescale 1ns/1ps
module dtg_qualify
    import dtg_pkg::*;
(
    input  logic    head_valid,
    input  logic    internal_only,
    input  logic    grant_in,
    input  logic    busy_in,
    input  logic    busy_own,
    input  logic    retry_in,
    output dq_act_t act
);
    always_comb begin
        if (!head_valid || internal_only) begin
            act = DQ_IDLE;
        end else if (retry_in) begin
            act = DQ_DROP;
        end else if (grant_in && !busy_in && !busy_own) begin
            act = DQ_GO;
        end else begin
            act = DQ_HOLD;
        end
    end

endmodule

// File: rtl/data_tenure_gate.sv
`timescale 1ns/1ps
module data_tenure_gate
    import dtg_pkg::*;
#(
    parameter int DEPTH       = 2,
    parameter int SHORT_BEATS = 1,
    parameter int LONG_BEATS  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic internal_only,
    input  logic xfer_start,
    input  logic addr_only,
    input  logic long_burst,
    input  logic grant_in,
    input  logic busy_in,
    input  logic retry_in,
    output logic tenure_start,
    output logic busy_out
);
    localparam int MAX_BEATS = (LONG_BEATS > SHORT_BEATS) ? LONG_BEATS : SHORT_BEATS;
    localparam int CNT_W     = $clog2(MAX_BEATS + 1);

    dtg_entry_t       push_data;
    dtg_entry_t       head_data;
    logic             head_valid;
    logic             push;
    logic             pop;
    logic             own_busy;
    logic [CNT_W-1:0] beats;
    dq_act_t          act;

    assign push                 = xfer_start && !addr_only && !internal_only;
    assign push_data.long_burst = long_burst;
    assign pop                  = (act == DQ_GO) || (act == DQ_DROP);
    assign beats = CNT_W'(tenure_beats(head_data.long_burst, SHORT_BEATS, LONG_BEATS));

    dtg_pend_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .flush      (internal_only),
        .push       (push),
        .push_data  (push_data),
        .pop        (pop),
        .head_valid (head_valid),
        .head_data  (head_data)
    );

    dtg_qualify u_qual (
        .head_valid    (head_valid),
        .internal_only (internal_only),
        .grant_in      (grant_in),
        .busy_in       (busy_in),
        .busy_own      (own_busy),
        .retry_in      (retry_in),
        .act           (act)
    );

    dtg_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (act == DQ_GO),
        .load_val (beats),
        .busy     (own_busy)
    );

    assign tenure_start = (act == DQ_GO);
    assign busy_out     = own_busy;

endmodule

// File: rtl/dtg_checker.sv
`timescale 1ns/1ps
module dtg_checker #(
    parameter int LONG_BEATS = 4
) (
    input logic clk,
    input logic rst,
    input logic internal_only,
    input logic grant_in,
    input logic busy_in,
    input logic retry_in,
    input logic tenure_start,
    input logic busy_out
);
    localparam int RUN_W = $clog2(LONG_BEATS + 1) + 1;

    logic [RUN_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
        end else if (busy_out) begin
            if (run != '1) run <= run + 1'b1;
        end else begin
            run <= '0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!tenure_start && !busy_out)); // R1
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        tenure_start |=> !tenure_start); // R4
    AST_NO_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !grant_in |-> !tenure_start); // R5
    AST_BUSY_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy_in |-> !tenure_start); // R6
    AST_RETRY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        retry_in |-> !tenure_start); // R7
    AST_BUSY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        tenure_start |=> busy_out); // R8
    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (run >= RUN_W'(LONG_BEATS)) |-> !busy_out); // R8
    AST_OWN_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy_out |-> !tenure_start); // R9
    AST_INTERNAL_OFF: assert property (@(posedge clk) disable iff (rst)
        internal_only |-> !tenure_start); // R11

endmodule

bind data_tenure_gate dtg_checker #(.LONG_BEATS(LONG_BEATS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .internal_only (internal_only),
    .grant_in      (grant_in),
    .busy_in       (busy_in),
    .retry_in      (retry_in),
    .tenure_start  (tenure_start),
    .busy_out      (busy_out)
);

// File: tb/data_tenure_gate_bench.sv
`timescale 1ns/1ps
module data_tenure_gate_bench;

    localparam int SHORT_N = 1;
    localparam int LONG_N  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic internal_only = 1'b0;
    logic xfer_start = 1'b0;
    logic addr_only = 1'b0;
    logic long_burst = 1'b0;
    logic grant_in = 1'b0;
    logic busy_in = 1'b0;
    logic retry_in = 1'b0;
    logic tenure_start;
    logic busy_out;

    int  checks = 0;
    int  fails  = 0;
    int  cyc    = 0;
    bit  done   = 1'b0;

    typedef struct {
        int    at;
        bit    lng;
        string req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    data_tenure_gate u_data_tenure_gate (
        .clk           (clk),
        .rst           (rst),
        .internal_only (internal_only),
        .xfer_start    (xfer_start),
        .addr_only     (addr_only),
        .long_burst    (long_burst),
        .grant_in      (grant_in),
        .busy_in       (busy_in),
        .retry_in      (retry_in),
        .tenure_start  (tenure_start),
        .busy_out      (busy_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // One cycle window: inputs change at the falling edge.
    task automatic drv(input bit xs, input bit ao, input bit lb,
                       input bit gr, input bit bi, input bit rt);
        @(negedge clk);
        cyc++;
        xfer_start = xs;
        addr_only  = ao;
        long_burst = lb;
        grant_in   = gr;
        busy_in    = bi;
        retry_in   = rt;
    endtask

    task automatic want(input int at, input bit lng, input string req);
        exp_t e;
        e.at = at; e.lng = lng; e.req = req;
        sb.push_back(e);
    endtask

    task automatic quiet(input string req);
        #2;
        chk(tenure_start == 1'b0, req, "no start", int'(tenure_start), 0);
    endtask

    task automatic settle(input int n, input string req);
        for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 0, 0);
        #2;
        chk(sb.size() == 0, req, "expected starts outstanding", sb.size(), 0);
    endtask

    // Monitor: pops expected starts and measures busy length.
    initial begin
        int run = 0;
        int exp_len = 0;
        string len_req = "R8";
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                if (busy_out) begin
                    run++;
                end else if (run != 0) begin
                    chk(run == exp_len, len_req, "busy_out length", run, exp_len);
                    run = 0;
                end
                if (tenure_start) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R4", "unexpected start", 1, 0);
                        exp_len = 0;
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        chk(cyc == e.at, e.req, "start cycle", cyc, e.at);
                        exp_len = e.lng ? LONG_N : SHORT_N;
                        len_req = {e.req, "/R8"};
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        chk(tenure_start == 1'b0, "R1", "start after reset", int'(tenure_start), 0);
        chk(busy_out == 1'b0, "R1", "busy after reset", int'(busy_out), 0);

        // R2: grant with empty queue
        for (int i = 0; i < 3; i++) begin drv(0, 0, 0, 1, 0, 0); quiet("R2"); end

        // R2 / R8: short tenure starts next cycle
        drv(1, 0, 0, 0, 0, 0);
        want(cyc + 1, 0, "R2");
        drv(0, 0, 0, 1, 0, 0);
        settle(4, "R2");

        // R3: address-only strobe with grant held
        drv(1, 1, 0, 1, 0, 0); quiet("R3");
        for (int i = 0; i < 3; i++) begin drv(0, 0, 0, 1, 0, 0); quiet("R3"); end

        // R5: grant low holds a long tenure
        drv(1, 0, 1, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin drv(0, 0, 0, 0, 0, 0); quiet("R5"); end
        want(cyc + 1, 1, "R5");
        drv(0, 0, 0, 1, 0, 0);
        settle(7, "R5");

        // R6: shared busy holds a tenure
        drv(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) begin drv(0, 0, 0, 1, 1, 0); quiet("R6"); end
        want(cyc + 1, 0, "R6");
        drv(0, 0, 0, 1, 0, 0);
        settle(4, "R6");

        // R7: retry removes short head, long entry starts next
        drv(1, 0, 0, 0, 0, 0);
        drv(1, 0, 1, 0, 0, 0);
        drv(0, 0, 0, 1, 0, 1); quiet("R7");
        want(cyc + 1, 1, "R7");
        drv(0, 0, 0, 1, 0, 0);
        settle(7, "R7");

        // R9: two queued tenures, own busy blocks the second
        drv(1, 0, 1, 0, 0, 0);
        drv(1, 0, 0, 0, 0, 0);
        want(cyc + 1, 1, "R9");
        want(cyc + 6, 0, "R9");
        drv(0, 0, 0, 1, 0, 0);
        drv(0, 0, 0, 1, 0, 0);
        #2;
        chk(busy_out == 1'b1, "R9", "busy while long tenure", int'(busy_out), 1);
        chk(tenure_start == 1'b0, "R9", "second start blocked", int'(tenure_start), 0);
        for (int i = 0; i < 5; i++) drv(0, 0, 0, 1, 0, 0);
        settle(4, "R9");

        // R10: third strobe dropped while two queued
        drv(1, 0, 0, 0, 0, 0);
        drv(1, 0, 1, 0, 0, 0);
        drv(1, 0, 0, 0, 0, 0);
        want(cyc + 1, 0, "R10");
        want(cyc + 3, 1, "R10");
        for (int i = 0; i < 7; i++) drv(0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 3; i++) begin drv(0, 0, 0, 1, 0, 0); quiet("R10"); end
        settle(2, "R10");

        // R11: internal-only mode
        internal_only = 1'b1;
        drv(1, 0, 0, 1, 0, 0); quiet("R11");
        drv(0, 0, 0, 1, 0, 0); quiet("R11");
        internal_only = 1'b0;
        drv(0, 0, 0, 1, 0, 0); quiet("R11");
        drv(1, 0, 0, 0, 0, 0);
        internal_only = 1'b1;
        drv(0, 0, 0, 1, 0, 0); quiet("R11");
        internal_only = 1'b0;
        drv(0, 0, 0, 1, 0, 0); quiet("R11");
        drv(0, 0, 0, 1, 0, 0); quiet("R11");

        // R4: strobe during a start is queued behind it
        drv(1, 0, 0, 0, 0, 0);
        want(cyc + 1, 0, "R4");
        want(cyc + 3, 0, "R4");
        drv(1, 0, 0, 1, 0, 0);
        drv(0, 0, 0, 1, 0, 0); quiet("R4");
        drv(0, 0, 0, 1, 0, 0);
        settle(4, "R4");

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule